// File: doc/BRIEF.md
# I/O Cycle Target with Wait-State Stretching

This block is the peripheral side of a legacy I/O bus. It watches the host's address and the active-low read and write strobes, decides whether the address falls inside its own window, and serves a small bank of 16-bit registers. On a read it raises a data-drive enable and places the selected register on its data output. On a write it collects address, data and byte lanes while the strobe is held, and commits them to the register when the strobe is released.

Cycles that a DMA controller runs, flagged by the address-enable input being high, are ignored completely. A parameter sets the number of bus clocks for which the ready line is held low at the start of each matching strobe. The 16-bit chip-select output is asserted for every matching address. Both strobes pass through a two-flop synchronizer before any edge detection.

Top module: `isa_io_target`

## Requirements
- R1: After reset all registers read as 0, data_oe_o is 0, iochrdy_o is 1 and iocs16_no is 1.
- R2: iocs16_no is 0 exactly when aen_i is 0 and addr_i[ADDR_W-1:3] equals BASE[ADDR_W-1:3] (with the default 4 registers the window is BASE to BASE+7); otherwise it is 1.
- R3: While aen_i is 1 the target does not respond: no register changes, data_oe_o stays 0, iochrdy_o stays 1 and iocs16_no stays 1.
- R4: A write commits on the release of iowr_ni. The register is unchanged while the strobe is held and for the first two clocks after the release. The new value appears after the third rising clock edge.
- R5: Write lanes follow the bus rule. The register index is addr_i[2:1]. The low byte is written when addr_i[0] is 0 and takes data_i[7:0]. The high byte is written when sbhe_ni is 0 and takes data_i[15:8].
- R6: With a matching address and iord_ni held low, data_oe_o is 0 after the first rising edge and 1 after the second. data_o then carries the full 16-bit register at index addr_i[2:1].
- R7: data_oe_o drops to 0 in the same cycle that iord_ni goes high, and data_o is 0 whenever data_oe_o is 0.
- R8: When a strobe is asserted on a matching address, iochrdy_o goes low at once and stays low for exactly WAIT_CLKS clock periods (default 3). With WAIT_CLKS of 0 it never goes low. It is never low on a non-matching address.
- R9: A write to an address outside the window leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | I/O address |
| data_i | input | 16 | Write data from the bus |
| sbhe_ni | input | 1 | Upper byte lane enable, active low |
| aen_i | input | 1 | High while DMA owns the bus |
| iord_ni | input | 1 | Read strobe, active low |
| iowr_ni | input | 1 | Write strobe, active low |
| data_o | output | 16 | Read data |
| data_oe_o | output | 1 | Read data drive enable |
| iochrdy_o | output | 1 | Ready line; low stretches the cycle |
| iocs16_no | output | 1 | 16-bit transfer flag, active low |
| regs_o | output | NREGS*16 | Register contents, index 0 in the low bits |

## Verification
The hardest case to reach is the commit window. The strobe has already been released on the pins, but the synchronized copy has not yet seen the release, so the register must still hold its old value. The stimulus releases the write strobe on a falling edge and then samples regs_o on each of the next three falling edges. This pins the commit to one exact cycle. Random writes that mix lane patterns, window edges and DMA-owned cycles then build up a register state that every later read must reproduce.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
  localparam int DW = 16;

  typedef struct packed {
    logic hi;
    logic lo;
  } lane_t;

  function automatic lane_t lanes_of(input logic a0, input logic sbhe_n);
    lane_t l;
    l.lo = ~a0;
    l.hi = ~sbhe_n;
    return l;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] d,
                                          input lane_t l);
    logic [DW-1:0] r;
    r = old;
    if (l.lo) r[DW/2-1:0]  = d[DW/2-1:0];
    if (l.hi) r[DW-1:DW/2] = d[DW-1:DW/2];
    return r;
  endfunction
endpackage

// File: rtl/isa_strobe_sync.sv
module isa_strobe_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strb_ni,
  output logic [N-1:0] act_o,
  output logic [N-1:0] rel_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= strb_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign act_o = ~s2_q;
  assign rel_o = s2_q & ~s3_q;
endmodule

// File: rtl/isa_addr_decode.sv
module isa_addr_decode #(
  parameter int          ADDR_W = 10,
  parameter int          IDX_W  = 2,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic                  aen_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  sbhe_ni,
  output logic                  match_o,
  output logic [IDX_W-1:0]      idx_o,
  output isa_io_pkg::lane_t     lanes_o
);
  localparam int LO = IDX_W + 1;

  assign match_o = ~aen_i & (addr_i[ADDR_W-1:LO] == BASE[ADDR_W-1:LO]);
  assign idx_o   = addr_i[IDX_W:1];
  assign lanes_o = isa_io_pkg::lanes_of(addr_i[0], sbhe_ni);
endmodule

// File: rtl/isa_wait_gen.sv
module isa_wait_gen #(
  parameter int WAIT_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rdy_o
);
  generate
    if (WAIT_CLKS == 0) begin : g_none
      assign rdy_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(WAIT_CLKS + 1);
      localparam logic [CW-1:0] LIM = CW'(WAIT_CLKS);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (!req_i)        cnt_q <= '0;
        else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
      end

      // low from the first sight of the request, for whole clocks only
      assign rdy_o = ~(req_i & (cnt_q != LIM));
    end
  endgenerate
endmodule

// File: rtl/isa_reg_bank.sv
module isa_reg_bank #(
  parameter int NREGS = 4,
  parameter int IDX_W = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cap_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  isa_io_pkg::lane_t                 lanes_i,
  input  logic [isa_io_pkg::DW-1:0]         data_i,
  input  logic                              commit_i,
  output logic [NREGS*isa_io_pkg::DW-1:0]   regs_o
);
  localparam int DW = isa_io_pkg::DW;

  logic                 pend_q;
  logic [IDX_W-1:0]     idx_q;
  isa_io_pkg::lane_t    lanes_q;
  logic [DW-1:0]        data_q;
  logic                 do_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      idx_q   <= '0;
      lanes_q <= '0;
      data_q  <= '0;
    end else if (cap_i) begin
      pend_q  <= 1'b1;
      idx_q   <= idx_i;
      lanes_q <= lanes_i;
      data_q  <= data_i;
    end else if (do_wr) begin
      pend_q  <= 1'b0;
    end
  end

  assign do_wr = commit_i & pend_q & ~cap_i;

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
      logic [DW-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          r_q <= '0;
        else if (do_wr && idx_q == IDX_W'(g))
          r_q <= isa_io_pkg::merge(r_q, data_q, lanes_q);
      end
      assign regs_o[g*DW +: DW] = r_q;
    end
  endgenerate
endmodule

// File: rtl/isa_io_target.sv
module isa_io_target #(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE      = 10'h300,
  parameter int                NREGS     = 4,
  parameter int                WAIT_CLKS = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [15:0]                       data_i,
  input  logic                              sbhe_ni,
  input  logic                              aen_i,
  input  logic                              iord_ni,
  input  logic                              iowr_ni,
  output logic [15:0]                       data_o,
  output logic                              data_oe_o,
  output logic                              iochrdy_o,
  output logic                              iocs16_no,
  output logic [NREGS*16-1:0]               regs_o
);
  localparam int DW    = isa_io_pkg::DW;
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic              match;
  logic [IDX_W-1:0]  idx;
  isa_io_pkg::lane_t lanes;
  logic [1:0]        act, rel;
  logic              strb_any;

  isa_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_dec (
    .aen_i(aen_i), .addr_i(addr_i), .sbhe_ni(sbhe_ni),
    .match_o(match), .idx_o(idx), .lanes_o(lanes)
  );

  // bit 0: read, bit 1: write
  isa_strobe_sync #(.N(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .strb_ni({iowr_ni, iord_ni}), .act_o(act), .rel_o(rel)
  );

  assign strb_any = ~iord_ni | ~iowr_ni;

  isa_wait_gen #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(match & strb_any), .rdy_o(iochrdy_o)
  );

  isa_reg_bank #(.NREGS(NREGS), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_i(match & ~iowr_ni), .idx_i(idx), .lanes_i(lanes),
    .data_i(data_i), .commit_i(rel[1]), .regs_o(regs_o)
  );

  assign iocs16_no = ~match;
  assign data_oe_o = act[0] & ~iord_ni & match;
  assign data_o    = data_oe_o ? regs_o[idx*DW +: DW] : '0;
endmodule

// File: rtl/isa_io_target_chk.sv
module isa_io_target_chk #(
  parameter int NREGS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               aen_i,
  input logic               iord_ni,
  input logic               iowr_ni,
  input logic [15:0]        data_o,
  input logic               data_oe_o,
  input logic               iochrdy_o,
  input logic               iocs16_no,
  input logic [NREGS*16-1:0] regs_o
);
  // R3
  dma_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> (iocs16_no && !data_oe_o && iochrdy_o));

  // R7
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iord_ni |-> !data_oe_o);

  // R7
  data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  // R8
  wait_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iochrdy_o |-> (!iocs16_no && (!iord_ni || !iowr_ni)));

  // R4
  commit_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o != $past(regs_o)) |-> $past(iowr_ni));

  // R6
  oe_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !iocs16_no);
endmodule

bind isa_io_target isa_io_target_chk #(.NREGS(NREGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .aen_i(aen_i), .iord_ni(iord_ni),
  .iowr_ni(iowr_ni), .data_o(data_o), .data_oe_o(data_oe_o),
  .iochrdy_o(iochrdy_o), .iocs16_no(iocs16_no), .regs_o(regs_o)
);

// File: tb/isa_io_target_tb_top.sv
module isa_io_target_tb_top;
  localparam int          ADDR_W = 10;
  localparam logic [9:0]  BASE   = 10'h300;
  localparam int          NREGS  = 4;
  localparam int          WAITS  = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [15:0]       data_i = '0;
  logic              sbhe_ni = 1'b1, aen_i = 1'b0, iord_ni = 1'b1, iowr_ni = 1'b1;
  logic [15:0]       data_o;
  logic              data_oe_o, iochrdy_o, iocs16_no;
  logic [NREGS*16-1:0] regs_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NREGS];

  always #10 clk_i = ~clk_i;

  isa_io_target #(.ADDR_W(ADDR_W), .BASE(BASE), .NREGS(NREGS), .WAIT_CLKS(WAITS)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
    .sbhe_ni(sbhe_ni), .aen_i(aen_i), .iord_ni(iord_ni), .iowr_ni(iowr_ni),
    .data_o(data_o), .data_oe_o(data_oe_o), .iochrdy_o(iochrdy_o),
    .iocs16_no(iocs16_no), .regs_o(regs_o)
  );

  function automatic logic hit(input logic [9:0] a, input logic aen);
    return !aen && (a[9:3] == BASE[9:3]);
  endfunction

  function automatic logic [15:0] upd(input logic [15:0] old, input logic [15:0] d,
                                      input logic a0, input logic sbhe_n);
    logic [15:0] r = old;
    if (!a0)     r[7:0]  = d[7:0];
    if (!sbhe_n) r[15:8] = d[15:8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREGS; i++) chk(req, 64'(regs_o[i*16 +: 16]), 64'(model[i]));
  endtask

  task automatic do_write(input logic [9:0] a, input logic [15:0] d,
                          input logic sbhe_n, input logic aen);
    int lows;
    logic h = hit(a, aen);
    @(negedge clk_i);
    addr_i = a; data_i = d; sbhe_ni = sbhe_n; aen_i = aen;
    #1;
    chk("R2 cs16", 64'(iocs16_no), 64'(!h));
    @(negedge clk_i);
    iowr_ni = 1'b0;
    #1;
    lows = 0;
    for (int k = 0; k < 10; k++) begin
      if (!iochrdy_o) lows++;
      @(negedge clk_i);
    end
    chk(h ? "R8 wait length" : "R3 R8 no wait", 64'(lows), 64'(h ? WAITS : 0));
    chk_regs("R4 held");
    iowr_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk_regs("R4 two clocks after release");
    @(negedge clk_i);
    if (h) model[a[2:1]] = upd(model[a[2:1]], d, a[0], sbhe_n);
    chk_regs(h ? "R5 committed" : "R3 R9 unchanged");
    @(negedge clk_i);
    aen_i = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, input logic aen);
    logic h = hit(a, aen);
    @(negedge clk_i);
    addr_i = a; aen_i = aen; sbhe_ni = 1'b0;
    iord_ni = 1'b0;
    @(negedge clk_i);
    chk("R6 oe after one clock", 64'(data_oe_o), 64'(0));
    @(negedge clk_i);
    chk("R6 oe after two clocks", 64'(data_oe_o), 64'(h));
    chk("R6 read data", 64'(data_o), h ? 64'(model[a[2:1]]) : 64'(0));
    @(posedge clk_i);
    #2;
    iord_ni = 1'b1;
    #1;
    chk("R7 oe drops", 64'(data_oe_o), 64'(0));
    chk("R7 data zero", 64'(data_o), 64'(0));
    @(negedge clk_i);
    aen_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 oe", 64'(data_oe_o), 64'(0));
    chk("R1 rdy", 64'(iochrdy_o), 64'(1));
    chk("R1 cs16", 64'(iocs16_no), 64'(1));
    chk_regs("R1 regs");
    rst_ni = 1'b1;
    // directed corners
    do_write(10'h300, 16'hbeef, 1'b0, 1'b0);
    do_write(10'h303, 16'ha55a, 1'b0, 1'b0);
    do_write(10'h304, 16'h1234, 1'b1, 1'b0);
    do_write(10'h307, 16'hc0de, 1'b0, 1'b0);
    do_write(10'h302, 16'hffff, 1'b0, 1'b1);
    do_write(10'h2ff, 16'h7777, 1'b0, 1'b0);
    do_write(10'h308, 16'h8888, 1'b0, 1'b0);
    do_read(10'h300, 1'b0);
    do_read(10'h306, 1'b0);
    do_read(10'h304, 1'b1);
    do_read(10'h310, 1'b0);
    for (int n = 0; n < 40; n++) begin
      logic [9:0] a = 10'h2f8 + 10'($urandom_range(0, 23));
      logic aen = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 1) == 1)
        do_write(a, 16'($urandom), 1'($urandom), aen);
      else
        do_read(a, aen);
    end
    for (int i = 0; i < NREGS; i++) do_read(BASE + 10'(2 * i), 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule